// File: doc/BRIEF.md
# Dependence-Set Index Sequencer

This block walks a three-deep loop nest whose dependences have been reduced to a triangular matrix with diagonal (1, 4, 13). A caller picks one of the 52 independent sets by giving a label (a, b, c) with a in 1..1, b in 1..4 and c in 1..13, and pulses `start`. The block then streams every (I1, I2, I3) triple of that set in lexicographic order on a valid/ready output. The final triple carries `out_last`, and `done` pulses once afterwards. Running all 52 labels one after another covers the 16×16×16 index space exactly once, so different labels can be given to different compute engines.

Only the outer index starts at the label value. The middle and inner loops start at offsets found with a floor-modulo of the label and of the running quotients y1 and y2. They then advance by their diagonal step up to the index bound. The control is a state machine with six states. IDLE waits for `start` (IDLE→OUTER). OUTER finds the middle start for the current I1 (OUTER→MID, OUTER→OUTER on an empty middle loop, OUTER→FLUSH once I1 passes the bound). MID finds the inner start for the current I2 (MID→HAVE, MID→MID or MID→OUTER on an empty inner loop). HAVE holds a found triple and steps the loops whenever the output register can take it (HAVE→HAVE, HAVE→MID, HAVE→OUTER). FLUSH offers the final buffered triple with `out_last` (FLUSH→DONE on handshake). DONE pulses `done` (DONE→IDLE).

Top module: `ldg_seq_top`

## Requirements
- R1: After reset, `out_valid` and `done` are low, and they stay low until a `start` is given.
- R2: `start` is taken only in IDLE, where it latches the label. A `start` given while a set is running is ignored and does not change the running sequence.
- R3: The outer index runs from the first label component up to 16 in steps of 1, with y1 = I1 − a. Every emitted index lies in 1..16.
- R4: For each I1, the middle index starts at 1 + ((b − 1 − 2·y1) mod 4) and steps by 4 up to 16. Here y2 = (I2 − b + 2·y1)/4.
- R5: For each (I1, I2), the inner index starts at 1 + ((c − 1 + 4·y1 + 2·y2) mod 13) and steps by 13 up to 16.
- R6: Every modulo result is a floor modulo in 0..divisor−1, including for negative dividends.
- R7: Within a label, triples come out in strictly increasing lexicographic order, each triple exactly once.
- R8: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and the triple does not change.
- R9: `out_last` is high on the final triple of the set and low on every other triple.
- R10: `done` is high for exactly one cycle, the cycle right after the handshake of the triple marked last.
- R11: Over all 52 labels, every point of the 16×16×16 space is emitted exactly once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a set; taken only in IDLE |
| label1 | input | 5 | Outer label component (1..1) |
| label2 | input | 5 | Middle label component (1..4) |
| label3 | input | 5 | Inner label component (1..13) |
| out_valid | output | 1 | Triple on `out_i*` is offered |
| out_ready | input | 1 | Consumer accepts the offered triple |
| out_i1 | output | 5 | Outer index |
| out_i2 | output | 5 | Middle index |
| out_i3 | output | 5 | Inner index |
| out_last | output | 1 | Offered triple is the final one of the set |
| done | output | 1 | One-cycle pulse after the final handshake |

## Verification
The bench builds each set's expected triple list from the formulas with a floor-modulo helper. It compares every handshake against that list under stall patterns that are either always-ready or pseudo-random. A truncating modulo on negative dividends (b − 1 − 2·y1 becomes negative from y1 = 1) would shift the middle offset, emit wrong triples and leave holes in the 4096-point cover. A `start` injected mid-run would restart or corrupt the set if it were not ignored. Stalls on the final triple show whether `out_last` or `done` come early or late, or whether a triple changes while it is held.

// File: rtl/ldg_pkg.sv
package ldg_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_OUTER,
        ST_MID,
        ST_HAVE,
        ST_FLUSH,
        ST_DONE
    } ldg_state_e;

endpackage

// File: rtl/ldg_floor_mod.sv
module ldg_floor_mod #(
    parameter int DIV = 4,
    parameter int W   = 13
) (
    input  logic signed [W-1:0] num,
    output logic signed [W-1:0] rem
);
    localparam logic signed [W-1:0] DV = W'(DIV);

    generate
        if (DIV == 1) begin : g_unit
            assign rem = '0;
        end else begin : g_mod
            logic signed [W-1:0] raw;
            always_comb begin
                raw = num % DV;
                if (raw < 0) begin
                    rem = raw + DV;
                end else begin
                    rem = raw;
                end
            end
        end
    endgenerate

endmodule

// File: rtl/ldg_hold_reg.sv
module ldg_hold_reg #(
    parameter int W = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic         drop,
    input  logic [W-1:0] d1,
    input  logic [W-1:0] d2,
    input  logic [W-1:0] d3,
    output logic [W-1:0] q1,
    output logic [W-1:0] q2,
    output logic [W-1:0] q3,
    output logic         full
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q1   <= '0;
            q2   <= '0;
            q3   <= '0;
            full <= 1'b0;
        end else if (load) begin
            q1   <= d1;
            q2   <= d2;
            q3   <= d3;
            full <= 1'b1;
        end else if (drop) begin
            full <= 1'b0;
        end
    end
endmodule

// File: rtl/ldg_seq_top.sv
module ldg_seq_top
    import ldg_pkg::*;
#(
    parameter int IDX_MAX = 16,
    parameter int DIAG1   = 1,
    parameter int DIAG2   = 4,
    parameter int DIAG3   = 13,
    parameter int K21     = 2,
    parameter int K31     = 4,
    parameter int K32     = 2
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           start,
    input  logic [$clog2(IDX_MAX+1)-1:0]   label1,
    input  logic [$clog2(IDX_MAX+1)-1:0]   label2,
    input  logic [$clog2(IDX_MAX+1)-1:0]   label3,
    output logic                           out_valid,
    input  logic                           out_ready,
    output logic [$clog2(IDX_MAX+1)-1:0]   out_i1,
    output logic [$clog2(IDX_MAX+1)-1:0]   out_i2,
    output logic [$clog2(IDX_MAX+1)-1:0]   out_i3,
    output logic                           out_last,
    output logic                           done
);
    localparam int IW = $clog2(IDX_MAX + 1);
    localparam int CW = IW + 8;
    localparam logic signed [CW-1:0] MAXS = CW'(IDX_MAX);
    localparam logic signed [CW-1:0] ONE  = CW'(1);
    localparam logic signed [CW-1:0] D1S  = CW'(DIAG1);
    localparam logic signed [CW-1:0] D2S  = CW'(DIAG2);
    localparam logic signed [CW-1:0] D3S  = CW'(DIAG3);
    localparam logic signed [CW-1:0] K21S = CW'(K21);
    localparam logic signed [CW-1:0] K31S = CW'(K31);
    localparam logic signed [CW-1:0] K32S = CW'(K32);

    ldg_state_e state, state_nx;

    logic signed [CW-1:0] lab2, lab3;
    logic signed [CW-1:0] c1, c2, c3;
    logic signed [CW-1:0] y1, y2;
    logic signed [CW-1:0] num2, num3, rem2, rem3;
    logic signed [CW-1:0] start2, start3, y2_init;
    logic signed [CW-1:0] nxt1, nxt2, nxt3;
    logic                 buf_full, take, drop;

    // ---------------- offset arithmetic ----------------
    always_comb begin
        num2    = lab2 - ONE - K21S * y1;
        num3    = lab3 - ONE + K31S * y1 + K32S * y2;
        start2  = rem2 + ONE;
        start3  = rem3 + ONE;
        y2_init = (rem2 - num2) / D2S;
        nxt1    = c1 + D1S;
        nxt2    = c2 + D2S;
        nxt3    = c3 + D3S;
    end

    ldg_floor_mod #(.DIV(DIAG2), .W(CW)) u_mod_mid (
        .num (num2),
        .rem (rem2)
    );

    ldg_floor_mod #(.DIV(DIAG3), .W(CW)) u_mod_inner (
        .num (num3),
        .rem (rem3)
    );

    // ---------------- state register ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    // ---------------- transitions ----------------
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (start) state_nx = ST_OUTER;
            end
            ST_OUTER: begin
                if (c1 > MAXS) begin
                    state_nx = ST_FLUSH;
                end else if (start2 <= MAXS) begin
                    state_nx = ST_MID;
                end
            end
            ST_MID: begin
                if (start3 <= MAXS) begin
                    state_nx = ST_HAVE;
                end else if (nxt2 > MAXS) begin
                    state_nx = ST_OUTER;
                end
            end
            ST_HAVE: begin
                if (take && nxt3 > MAXS) begin
                    state_nx = (nxt2 <= MAXS) ? ST_MID : ST_OUTER;
                end
            end
            ST_FLUSH: begin
                if (!buf_full || out_ready) state_nx = ST_DONE;
            end
            ST_DONE: begin
                state_nx = ST_IDLE;
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    // ---------------- loop counters ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lab2 <= '0;
            lab3 <= '0;
            c1   <= '0;
            c2   <= '0;
            c3   <= '0;
            y1   <= '0;
            y2   <= '0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (start) begin
                        lab2 <= $signed({{(CW-IW){1'b0}}, label2});
                        lab3 <= $signed({{(CW-IW){1'b0}}, label3});
                        c1   <= $signed({{(CW-IW){1'b0}}, label1});
                        y1   <= '0;
                    end
                end
                ST_OUTER: begin
                    if (c1 <= MAXS) begin
                        if (start2 > MAXS) begin
                            c1 <= nxt1;
                            y1 <= y1 + ONE;
                        end else begin
                            c2 <= start2;
                            y2 <= y2_init;
                        end
                    end
                end
                ST_MID: begin
                    if (start3 <= MAXS) begin
                        c3 <= start3;
                    end else if (nxt2 <= MAXS) begin
                        c2 <= nxt2;
                        y2 <= y2 + ONE;
                    end else begin
                        c1 <= nxt1;
                        y1 <= y1 + ONE;
                    end
                end
                ST_HAVE: begin
                    if (take) begin
                        if (nxt3 <= MAXS) begin
                            c3 <= nxt3;
                        end else if (nxt2 <= MAXS) begin
                            c2 <= nxt2;
                            y2 <= y2 + ONE;
                        end else begin
                            c1 <= nxt1;
                            y1 <= y1 + ONE;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    // ---------------- output stage ----------------
    always_comb begin
        take = (state == ST_HAVE)  && (!buf_full || out_ready);
        drop = (state == ST_FLUSH) && buf_full && out_ready;
    end

    ldg_hold_reg #(.W(IW)) u_hold (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (take),
        .drop  (drop),
        .d1    (c1[IW-1:0]),
        .d2    (c2[IW-1:0]),
        .d3    (c3[IW-1:0]),
        .q1    (out_i1),
        .q2    (out_i2),
        .q3    (out_i3),
        .full  (buf_full)
    );

    always_comb begin
        out_valid = buf_full && ((state == ST_HAVE) || (state == ST_FLUSH));
        out_last  = buf_full && (state == ST_FLUSH);
        done      = (state == ST_DONE);
    end

    // ---------------- assertions ----------------
    logic          fire;
    logic          chk_have;
    logic [IW-1:0] chk_p1, chk_p2, chk_p3;

    assign fire = out_valid && out_ready;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chk_have <= 1'b0;
            chk_p1   <= '0;
            chk_p2   <= '0;
            chk_p3   <= '0;
        end else if (state == ST_IDLE) begin
            chk_have <= 1'b0;
        end else if (fire) begin
            chk_have <= 1'b1;
            chk_p1   <= out_i1;
            chk_p2   <= out_i2;
            chk_p3   <= out_i3;
        end
    end

    p_hold_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_i1) && $stable(out_i2) && $stable(out_i3));

    p_index_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_i1 >= 1) && (int'(out_i1) <= IDX_MAX) && (out_i2 >= 1) &&
                      (int'(out_i2) <= IDX_MAX) && (out_i3 >= 1) && (int'(out_i3) <= IDX_MAX));

    p_lex_order_r7: assert property (@(posedge clk) disable iff (!rst_n)
        fire && chk_have |-> {out_i1, out_i2, out_i3} > {chk_p1, chk_p2, chk_p3});

    p_inner_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        fire && chk_have && out_i1 == chk_p1 && out_i2 == chk_p2 |->
            int'(out_i3) == int'(chk_p3) + DIAG3);

    p_mid_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        fire && chk_have && out_i1 == chk_p1 && out_i2 != chk_p2 |->
            ((int'(out_i2) - int'(chk_p2)) % DIAG2) == 0);

    p_done_source_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(fire && out_last));

    p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

endmodule

// File: tb/ldg_seq_top_tb_top.sv
module ldg_seq_top_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int WD_LIMIT   = 190000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic [4:0] label1 = '0, label2 = '0, label3 = '0;
    logic       out_valid, out_ready = 1'b0, out_last, done;
    logic [4:0] out_i1, out_i2, out_i3;

    ldg_seq_top dut_i (
        .clk(clk), .rst_n(rst_n), .start(start),
        .label1(label1), .label2(label2), .label3(label3),
        .out_valid(out_valid), .out_ready(out_ready),
        .out_i1(out_i1), .out_i2(out_i2), .out_i3(out_i3),
        .out_last(out_last), .done(done)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int         n_checks = 0;
    int         n_fail   = 0;
    int         cycles   = 0;
    bit         wd_hit   = 0;
    int         expq[$];
    int         hit[4096];
    logic [15:0] lfsr = 16'hACE1;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int pmod(input int a, input int m);
        int r;
        r = a % m;
        if (r < 0) r += m;
        return r;
    endfunction

    function automatic int enc(input int a, input int b, input int c);
        return a * 1024 + b * 32 + c;
    endfunction

    // reference list for one label (R3, R4, R5, R6)
    task automatic build(input int l1, input int l2, input int l3);
        expq.delete();
        for (int i1 = l1; i1 <= 16; i1++) begin
            int ya, s2;
            ya = i1 - l1;
            s2 = 1 + pmod(l2 - 1 - 2 * ya, 4);
            for (int i2 = s2; i2 <= 16; i2 += 4) begin
                int yb, s3;
                yb = (i2 - l2 + 2 * ya) / 4;
                s3 = 1 + pmod(l3 - 1 + 4 * ya + 2 * yb, 13);
                for (int i3 = s3; i3 <= 16; i3 += 13) expq.push_back(enc(i1, i2, i3));
            end
        end
    endtask

    task automatic run_label(input int l1, input int l2, input int l3, input int mode, input bit poke);
        int  lc, prev_trip, got, exp;
        bit  prev_stall, exp_done, fin;
        build(l1, l2, l3);
        @(negedge clk);
        label1 = 5'(l1); label2 = 5'(l2); label3 = 5'(l3);
        start = 1'b1; out_ready = 1'b0;
        @(negedge clk);
        start = 1'b0;
        lc = 0; prev_stall = 0; exp_done = 0; fin = 0; prev_trip = 0;
        while (!fin) begin
            // R2: a start while running must be ignored
            if (poke && lc == 3) begin
                start = 1'b1; label2 = 5'd3; label3 = 5'd9;
            end else if (poke && lc == 4) begin
                start = 1'b0;
            end
            if (prev_stall) begin
                got = enc(int'(out_i1), int'(out_i2), int'(out_i3));
                chk(out_valid && got == prev_trip, "R8 held triple", got, prev_trip);
            end
            chk(done == exp_done, "R10 done timing", int'(done), int'(exp_done));
            if (done) begin
                chk(expq.size() == 0, "R7 triples missing at done", expq.size(), 0);
                fin = 1;
            end else begin
                out_ready = (mode == 0) ? 1'b1 : lfsr[0];
                lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
                exp_done = 0; prev_stall = 0;
                if (out_valid) begin
                    got = enc(int'(out_i1), int'(out_i2), int'(out_i3));
                    if (expq.size() == 0) begin
                        chk(0, "R7 extra triple", got, 0);
                    end else if (out_ready) begin
                        exp = expq[0];
                        chk(got == exp, "R7 order/content", got, exp);
                        chk(out_last == (expq.size() == 1), "R9 last flag", int'(out_last),
                            int'(expq.size() == 1));
                        if (out_i1 >= 1 && out_i2 >= 1 && out_i3 >= 1 &&
                            out_i1 <= 16 && out_i2 <= 16 && out_i3 <= 16)
                            hit[(int'(out_i1)-1)*256 + (int'(out_i2)-1)*16 + int'(out_i3)-1]++;
                        void'(expq.pop_front());
                        exp_done = out_last;
                    end else begin
                        prev_stall = 1; prev_trip = got;
                    end
                end
                @(negedge clk);
                cycles++; lc++;
                if (cycles > WD_LIMIT) begin
                    wd_hit = 1; fin = 1;
                end
            end
        end
    endtask

    initial begin
        foreach (hit[k]) hit[k] = 0;
        repeat (3) @(negedge clk);
        chk(out_valid == 1'b0, "R1 reset valid", int'(out_valid), 0);
        chk(done == 1'b0, "R1 reset done", int'(done), 0);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        chk(out_valid == 1'b0, "R1 idle valid", int'(out_valid), 0);
        chk(done == 1'b0, "R1 idle done", int'(done), 0);

        for (int b = 1; b <= 4 && !wd_hit; b++) begin
            for (int c = 1; c <= 13 && !wd_hit; c++) begin
                run_label(1, b, c, (b + c) % 2, (c == 5));
            end
        end

        if (wd_hit) begin
            chk(0, "R11 watchdog expired", cycles, WD_LIMIT);
        end else begin
            // R11: full cover, each point once
            for (int k = 0; k < 4096; k++) chk(hit[k] == 1, "R11 cover", hit[k], 1);
        end
        $display("  TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end
endmodule